// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block times the interval between pulses from a fan's tachometer output. The pin is passed through a synchronizer and then a debounce filter of selectable depth. One of three edge policies picks which transitions of the filtered signal end one measurement and start the next. A prescaler divides the clock by a power of four, and a counter accumulates the prescaled ticks between consecutive qualifying edges. At each such edge the counter's value is latched into the status word. A loopback mode lets the block measure the channel's own PWM output instead of the pin.

The control word is a static level input decoded every cycle. The status word shows the latched count, a one-clock update pulse, a flag that marks a valid measurement, the raw and filtered input levels, and an interrupt flag. The interrupt flag is raised when a latched count passes a programmable limit in a selectable direction. Software turns the count into a speed; that arithmetic lies outside the block.

Top module: `fan_tach_meter`

## Requirements
- R1: Debounce code ctrl_i[27:26] = c requires the synchronized input to hold a new level for 4-c consecutive clocks before status bit 23 adopts it (code 0: 4, code 1: 3, code 2: 2, code 3: 1). Shorter pulses leave bit 23 unchanged.
- R2: Status bit 22 shows the input after a two-flop synchronizer. When ctrl_i[29] is 1, the input is pwm_loop_i; when it is 0, the input is tach_i.
- R3: Edge code ctrl_i[25:24] selects the measured edges: 0 falling-to-falling, 1 rising-to-rising, 2 every edge, and 3 behaves as 2.
- R4: With n = ctrl_i[23:20], the latched count for qualifying edges D clocks apart is floor(D / 4^n).
- R5: The first qualifying edge after enable only starts counting. The second edge latches the count into status bits [19:0] and sets status bit 20. Until then, bit 20 and the count read 0.
- R6: The count saturates at the all-ones value of CNT_W bits. Status bits above CNT_W read 0.
- R7: Status bit 21 is high for exactly one clock per latched measurement.
- R8: One clock after a latch, status bit 31 and irq_o are set if ctrl_i[31] is 1 and the count is above the limit ctrl_i[19:0]. When ctrl_i[30] is 1, the condition is a count below the limit instead. An equal count never sets the flag.
- R9: A one-clock pulse on irq_clr_i clears the interrupt flag.
- R10: With enable ctrl_i[28] at 0, the count, status bits 20, 21 and 31, and irq_o are held at 0, and the block is disarmed.
- R11: During reset, status_o and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word (enable, mode, divisor, limit) |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| tach_i | input | 1 | Tachometer pin |
| pwm_loop_i | input | 1 | Channel PWM output used in loopback |
| status_o | output | 32 | Status word (flag, levels, update, valid, count) |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with CNT_W = 8 and the default two-stage synchronizer. The narrow count makes saturation reachable within a few hundred clocks, so one table row can drive 400-clock intervals and expect 255. The remaining rows keep the prescaler exponent at 0 to 2, which makes floor division by 1, 4 and 16 directly visible. Debounce pulses one clock shorter and exactly as long as each code's hold window show the acceptance boundary.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int unsigned CNT_FIELD_W = 20;
  localparam int unsigned DIV_FIELD_W = 4;

  typedef enum logic [1:0] {
    EDGE_FALL  = 2'd0,
    EDGE_RISE  = 2'd1,
    EDGE_BOTH  = 2'd2,
    EDGE_BOTH2 = 2'd3
  } edge_sel_e;

  // field order is the control word bit order, msb first
  typedef struct packed {
    logic                   irq_en;
    logic                   inv_limit;
    logic                   loopback;
    logic                   enable;
    logic [1:0]             dbn;
    edge_sel_e              edge_sel;
    logic [DIV_FIELD_W-1:0] div_exp;
    logic [CNT_FIELD_W-1:0] limit;
  } tach_ctrl_t;
endpackage

// File: rtl/tach_front.sv
module tach_front
  import tach_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  logic      loop_i,
  input  logic      loopback_i,
  input  logic [1:0] dbn_i,
  input  edge_sel_e edge_sel_i,
  output logic      raw_o,
  output logic      deb_o,
  output logic      edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic       src, raw, deb_q, accept;
  logic [1:0] hold_q, hold_lim;

  assign src = loopback_i ? loop_i : pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], src};
  end

  assign raw      = sync_q[SYNC_STAGES-1];
  assign hold_lim = 2'd3 - dbn_i;
  assign accept   = (raw != deb_q) && (hold_q >= hold_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deb_q  <= 1'b0;
      hold_q <= '0;
    end else if (raw == deb_q) begin
      hold_q <= '0;
    end else if (accept) begin
      deb_q  <= raw;
      hold_q <= '0;
    end else begin
      hold_q <= hold_q + 2'd1;
    end
  end

  always_comb begin
    unique case (edge_sel_i)
      EDGE_FALL: edge_o = accept & ~raw;
      EDGE_RISE: edge_o = accept &  raw;
      default:   edge_o = accept;
    endcase
  end

  assign raw_o = raw;
  assign deb_o = deb_q;

  // R1: the filtered level only ever takes a level the synchronizer held
  a_r1_deb_from_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deb_q != $past(deb_q)) |-> (deb_q == $past(raw)));
  // R1: deepest filter needs the new level held across several cycles
  a_r1_deep_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbn_i == 2'd0 && $stable(dbn_i) && deb_q != $past(deb_q)) |-> ($past(raw, 2) == deb_q));
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler
  import tach_pkg::*;
#(
  parameter int unsigned PRE_W = 2 * ((1 << DIV_FIELD_W) - 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   restart_i,
  input  logic [DIV_FIELD_W-1:0] exp_i,
  output logic                   tick_o
);
  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);
  logic [PRE_W-1:0] pre_q, lim;

  // 4^n - 1; top exponent wraps to all ones, which is the same value
  assign lim    = (ONE << {exp_i, 1'b0}) - ONE;
  assign tick_o = (pre_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (restart_i || tick_o) pre_q <= '0;
    else                         pre_q <= pre_q + ONE;
  end

  // R4: the phase never runs past the selected divide
  a_r4_pre_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pre_q) == $past(lim) && $stable(exp_i)) |-> (pre_q == '0));
endmodule

// File: rtl/tach_counter.sv
module tach_counter #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             edge_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] value_o,
  output logic             full_o,
  output logic             upd_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, value_q, next_cnt;
  logic armed_q, full_q, upd_q;

  assign next_cnt = (tick_i && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; value_q <= '0; armed_q <= 1'b0; full_q <= 1'b0; upd_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0; value_q <= '0; armed_q <= 1'b0; full_q <= 1'b0; upd_q <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (edge_i) begin
        if (armed_q) begin
          value_q <= next_cnt;
          full_q  <= 1'b1;
          upd_q   <= 1'b1;
        end
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (armed_q) begin
        cnt_q <= next_cnt;
      end
    end
  end

  assign value_o = value_q;
  assign full_o  = full_q;
  assign upd_o   = upd_q;

  // R6: count moves by one or restarts, never wraps
  a_r6_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));
  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_q) == CNT_MAX && $past(en_i) && en_i && !$past(edge_i)) |-> (cnt_q == CNT_MAX));
  // R5: valid flag rises together with the first latch
  a_r5_full_with_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> upd_q);
  // R7: an update always reports a valid measurement
  a_r7_upd_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> full_q);
  // R10: disabled block holds everything at zero
  a_r10_off_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (!full_q && !upd_q && cnt_q == '0 && value_q == '0));
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import tach_pkg::*;
#(
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] ctrl_i,
  input  logic        irq_clr_i,
  input  logic        tach_i,
  input  logic        pwm_loop_i,
  output logic [31:0] status_o,
  output logic        irq_o
);
  localparam int unsigned PRE_W = 2 * ((1 << DIV_FIELD_W) - 1);

  tach_ctrl_t ctrl;
  logic raw, deb, qual_edge, tick, full, upd, hit, irq_q;
  logic [CNT_W-1:0]       value;
  logic [CNT_FIELD_W-1:0] value_ext;

  assign ctrl = tach_ctrl_t'(ctrl_i);

  tach_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni,
    .pin_i      (tach_i),
    .loop_i     (pwm_loop_i),
    .loopback_i (ctrl.loopback),
    .dbn_i      (ctrl.dbn),
    .edge_sel_i (ctrl.edge_sel),
    .raw_o      (raw),
    .deb_o      (deb),
    .edge_o     (qual_edge)
  );

  tach_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni,
    .restart_i (qual_edge),
    .exp_i     (ctrl.div_exp),
    .tick_o    (tick)
  );

  tach_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .en_i    (ctrl.enable),
    .edge_i  (qual_edge),
    .tick_i  (tick),
    .value_o (value),
    .full_o  (full),
    .upd_o   (upd)
  );

  assign value_ext = CNT_FIELD_W'(value);
  assign hit = ctrl.irq_en &&
               (ctrl.inv_limit ? (value_ext < ctrl.limit) : (value_ext > ctrl.limit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             irq_q <= 1'b0;
    else if (!ctrl.enable)   irq_q <= 1'b0;
    else if (upd && hit)     irq_q <= 1'b1;
    else if (irq_clr_i)      irq_q <= 1'b0;
  end

  assign irq_o    = irq_q;
  assign status_o = {irq_q, 7'b0, deb, raw, upd, full, value_ext};

  // R8: flag only rises on the cycle after a latch
  a_r8_irq_after_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(upd));
  // R9: clear strobe wins unless a new latch sets the flag
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(irq_clr_i) && !$past(upd)) |-> !irq_q);
endmodule

// File: tb/test_fan_tach_meter.sv
module test_fan_tach_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl = '0;
  logic        clr = 1'b0, tach = 1'b1, pwm = 1'b1;
  logic [31:0] status;
  logic        irq;
  int errs = 0, checks = 0, upd_seen = 0;
  bit counting = 1'b0;

  always #4 clk = ~clk;

  fan_tach_meter #(.CNT_W(8)) i_fan_tach_meter (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .irq_clr_i(clr),
    .tach_i(tach), .pwm_loop_i(pwm), .status_o(status), .irq_o(irq)
  );

  always @(negedge clk) if (counting && status[21]) upd_seen++;

  typedef struct packed {
    int edge_m; int dexp; int hi; int lo; int expv;
  } vec_t;
  localparam int VN = 8;
  localparam vec_t VEC [VN] = '{
    '{0, 0, 10,  20, 30},
    '{1, 0,  7,   5, 12},
    '{2, 0,  9,   9,  9},
    '{3, 0,  6,   6,  6},
    '{0, 1, 20,  20, 10},
    '{0, 1, 21,  20, 10},
    '{0, 2, 50,  50,  6},
    '{1, 0, 200, 200, 255}
  };

  function automatic logic [31:0] mk(bit ie, bit inv, bit lb, bit en,
                                     int dbn, int em, int dx, int thr);
    return {ie, inv, lb, en, 2'(dbn), 2'(em), 4'(dx), 20'(thr)};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] expv);
    checks++;
    if (got !== expv) begin
      errs++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, expv);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wave(int hi, int lo, int per, bit use_loop);
    for (int p = 0; p < per; p++) begin
      if (use_loop) pwm = 1'b0; else tach = 1'b0;
      cyc(lo);
      if (use_loop) pwm = 1'b1; else tach = 1'b1;
      cyc(hi);
    end
  endtask

  task automatic setup(logic [31:0] w);
    ctrl = '0; tach = 1'b1; pwm = 1'b1;
    cyc(8);
    ctrl = w;
    cyc(2);
  endtask

  task automatic glitch(string tag, int code, int len, bit pass);
    bit seen = 1'b0;
    ctrl = mk(0, 0, 0, 0, code, 0, 0, 0);
    tach = 1'b1;
    cyc(10);
    tach = 1'b0;
    for (int i = 0; i < len + 14; i++) begin
      @(negedge clk);
      if (status[23] == 1'b0) seen = 1'b1;
      if (i == len - 1) tach = 1'b1;
    end
    chk(tag, {31'b0, seen}, {31'b0, pass});
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R11 status in reset", status, 32'h0);
    chk("R11 irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    cyc(2);

    // R3 R4 R6 table walk
    for (int i = 0; i < VN; i++) begin
      string tag;
      tag = (i == VN - 1) ? "R6 saturate" : (VEC[i].dexp > 0) ? "R4 divide" : "R3 edge mode";
      setup(mk(0, 0, 0, 1, 3, VEC[i].edge_m, VEC[i].dexp, 0));
      wave(VEC[i].hi, VEC[i].lo, 4, 1'b0);
      cyc(10);
      chk(tag, {12'b0, status[19:0]}, 32'(VEC[i].expv));
      chk("R5 full after run", {31'b0, status[20]}, 32'd1);
    end

    // R10 disable clears
    ctrl[28] = 1'b0;
    cyc(2);
    chk("R10 disabled fields", {11'b0, status[20:0]}, 32'h0);

    // R5 one edge only starts
    setup(mk(0, 0, 0, 1, 3, 0, 0, 0));
    tach = 1'b0; cyc(10); tach = 1'b1; cyc(10);
    chk("R5 single edge valid", {31'b0, status[20]}, 32'd0);
    chk("R5 single edge count", {12'b0, status[19:0]}, 32'd0);
    tach = 1'b0; cyc(10); tach = 1'b1; cyc(10);
    chk("R5 second edge valid", {31'b0, status[20]}, 32'd1);
    chk("R5 second edge count", {12'b0, status[19:0]}, 32'd20);

    // R7 one-clock update per latch: 5 falls -> 4 latches
    setup(mk(0, 0, 0, 1, 3, 0, 0, 0));
    upd_seen = 0; counting = 1'b1;
    wave(10, 10, 5, 1'b0);
    cyc(10);
    counting = 1'b0;
    chk("R7 update pulses", 32'(upd_seen), 32'd4);

    // R2 raw level and loopback
    setup(mk(0, 0, 0, 0, 3, 0, 0, 0));
    tach = 1'b0; cyc(4);
    chk("R2 raw follows pin", {31'b0, status[22]}, 32'd0);
    tach = 1'b1;
    setup(mk(0, 0, 1, 1, 3, 0, 0, 0));
    pwm = 1'b0; cyc(4);
    chk("R2 raw follows loop", {31'b0, status[22]}, 32'd0);
    pwm = 1'b1; cyc(4);
    wave(8, 8, 4, 1'b1);
    cyc(10);
    chk("R2 loopback count", {12'b0, status[19:0]}, 32'd16);

    // R1 debounce depth boundaries
    glitch("R1 code0 len3", 0, 3, 1'b0);
    glitch("R1 code0 len4", 0, 4, 1'b1);
    glitch("R1 code1 len2", 1, 2, 1'b0);
    glitch("R1 code1 len3", 1, 3, 1'b1);
    glitch("R1 code2 len1", 2, 1, 1'b0);
    glitch("R1 code2 len2", 2, 2, 1'b1);

    // R8 limit compare, D = 30
    setup(mk(1, 0, 0, 1, 3, 0, 0, 20));
    wave(15, 15, 3, 1'b0); cyc(10);
    chk("R8 above limit irq", {31'b0, irq}, 32'd1);
    chk("R8 above limit flag", {31'b0, status[31]}, 32'd1);

    // R9 clear strobe
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(2);
    chk("R9 cleared", {31'b0, irq}, 32'd0);

    setup(mk(0, 0, 0, 1, 3, 0, 0, 20));
    wave(15, 15, 3, 1'b0); cyc(10);
    chk("R8 irq disabled", {31'b0, irq}, 32'd0);
    setup(mk(1, 1, 0, 1, 3, 0, 0, 40));
    wave(15, 15, 3, 1'b0); cyc(10);
    chk("R8 below inverted limit", {31'b0, irq}, 32'd1);
    ctrl[28] = 1'b0; cyc(2);
    chk("R10 irq cleared by disable", {31'b0, irq}, 32'd0);
    setup(mk(1, 1, 0, 1, 3, 0, 0, 30));
    wave(15, 15, 3, 1'b0); cyc(10);
    chk("R8 equal never fires", {31'b0, irq}, 32'd0);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule